// File: doc/BRIEF.md
# Single-Wire Monitor Serial Port

This block is the serial front end of a debug monitor that talks to a host over one shared data wire. The pad is modelled as three signals: the level seen on the wire (`pin_in`), the level to drive (`pin_out`) and a drive enable (`pin_oe`). An external pull-up holds the wire high whenever nobody drives it. Frames are plain NRZ bytes. Receive and transmit always use the same bit time. That bit time is a fixed count of bus clocks, chosen by a mode input that says which oscillator clocks the chip.

Bytes that arrive are handed to the host-side logic as a one-cycle valid pulse with the data. A byte to send is handed in with a request and goes out as soon as the wire is free. If the port is in the middle of receiving a frame, a transmit request waits until that frame ends.

A break from the host is a line held low for ten bit times. The port reports it with a one-cycle pulse and answers it with a fixed sequence: the wire is driven high for two bit times, then low for ten bit times as an echo of the break, then high for one more bit time. Only after that is the wire released. Frames whose stop bit is low, but which are not a break, are flagged as framing errors.

Top module: `mon_sio`

## Requirements
- R1: A received frame is a low start bit, eight data bits with bit 0 first, and a high stop bit. When the stop bit samples high, `rx_data` carries the byte and `rx_valid` pulses.
- R2: A transmitted byte appears on `pin_out` as a low start bit, data bits 0 to 7 in that order, and a high stop bit. `pin_oe` is high for exactly ten bit times per byte.
- R3: One bit time is DIV_EXT bus clocks when `osc_int_sel` is 0 and DIV_INT bus clocks when it is 1, with defaults 256 and 335. The same value applies to both receive and transmit.
- R4: After the falling edge of a start bit, the receiver samples the wire half a bit time later. If the wire is high at that point, the start is dropped as a glitch and no event is raised.
- R5: A start bit followed by nine more low bits, so that the stop position also reads low, raises a one-cycle `rx_break` pulse and no `rx_valid`.
- R6: After a break, the port drives high for two bit times, then low for ten bit times, then high for one bit time, so `pin_oe` is high for 13 bit times. After that it receives normally again.
- R7: A frame whose stop bit reads low but whose data bits are not all zero raises a one-cycle `rx_frame_err` pulse and no `rx_valid`.
- R8: `pin_oe` is low whenever nothing is being sent. The wire is released only after a bit time in which it was driven high.
- R9: A request made while `tx_ready` is high is accepted, and `tx_ready` then stays low until the frame has been sent. A request accepted during a reception is held until the stop bit of that reception has been sampled. `tx_busy` is high exactly while the port drives the wire.
- R10: `rx_valid`, `rx_break` and `rx_frame_err` are each one bus clock wide.
- R11: While the port drives the wire, no receive event is raised, because its own transmissions are not received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_int_sel | input | 1 | 0: bit time DIV_EXT clocks, 1: bit time DIV_INT clocks |
| pin_in | input | 1 | Level seen on the shared wire |
| pin_out | output | 1 | Level driven onto the wire when enabled |
| pin_oe | output | 1 | Drive enable for the wire, 0 releases it to the pull-up |
| tx_req | input | 1 | Request to send `tx_data`, taken when `tx_ready` is high |
| tx_data | input | 8 | Byte to send |
| tx_ready | output | 1 | A new request can be accepted |
| tx_busy | output | 1 | The port is driving the wire |
| rx_valid | output | 1 | One-cycle pulse: `rx_data` holds a received byte |
| rx_data | output | 8 | Last received byte |
| rx_break | output | 1 | One-cycle pulse: a break was received |
| rx_frame_err | output | 1 | One-cycle pulse: a frame had a low stop bit and was not a break |

## Verification
Some properties are checked on every cycle:
- the event outputs are single-cycle pulses;
- no receive event appears while the port drives the wire;
- a break pulse is followed at once by the port driving the wire high;
- a held request never starts while a reception is under way;
- the wire is released only from a high level.

Other behaviour can only be shown by the bench scenarios, which compare the wire cycle by cycle against frames worked out in the bench:
- the exact bit order and frame length;
- the two bit times and their mode selection;
- mid-bit glitch rejection;
- the telling apart of break and framing error;
- the full 13-bit echo and the return to normal reception after it.

// File: rtl/mon_sio_pkg.sv
package mon_sio_pkg;

   localparam int unsigned FRAME_BITS     = 10;
   localparam int unsigned ECHO_HI_BITS   = 2;
   localparam int unsigned BREAK_BITS     = 10;
   localparam int unsigned ECHO_TAIL_BITS = 1;
   localparam int unsigned ECHO_BITS      = ECHO_HI_BITS + BREAK_BITS + ECHO_TAIL_BITS;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_STOP,
      RX_WAIT_HI
   } rx_state_e;

   // Break answer, least significant bit goes on the wire first.
   function automatic logic [ECHO_BITS-1:0] echo_pattern();
      logic [ECHO_BITS-1:0] p;
      for (int i = 0; i < int'(ECHO_BITS); i++) begin
         p[i] = (i < int'(ECHO_HI_BITS)) || (i >= int'(ECHO_HI_BITS + BREAK_BITS));
      end
      return p;
   endfunction

   localparam logic [ECHO_BITS-1:0] ECHO_PAT = echo_pattern();

endpackage

// File: rtl/mon_sio_sync.sv
module mon_sio_sync #(
   parameter int unsigned STAGES = 2,
   parameter logic        INIT   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [STAGES:0] r;
         assign r[0] = d;
         for (genvar i = 1; i <= int'(STAGES); i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) r[i] <= INIT;
               else        r[i] <= r[i-1];
            end
         end
         assign q = r[STAGES];
      end
   endgenerate

endmodule

// File: rtl/mon_sio_rx.sv
module mon_sio_rx
   import mon_sio_pkg::*;
#(
   parameter int unsigned CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             line,
   input  logic [CNT_W-1:0] bit_len,
   output logic             busy,
   output logic             line_hi,
   output logic             valid,
   output logic [7:0]       data,
   output logic             brk,
   output logic             ferr
);

   rx_state_e        st_q;
   logic [CNT_W-1:0] cnt_q;
   logic [2:0]       idx_q;
   logic [7:0]       sh_q;
   logic [CNT_W-1:0] half_m1;
   logic [CNT_W-1:0] full_m1;

   assign half_m1 = (bit_len >> 1) - CNT_W'(1);
   assign full_m1 = bit_len - CNT_W'(1);
   assign busy    = (st_q != RX_IDLE);
   assign line_hi = line;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= RX_IDLE;
         cnt_q <= '0;
         idx_q <= '0;
         sh_q  <= '0;
         data  <= '0;
         valid <= 1'b0;
         brk   <= 1'b0;
         ferr  <= 1'b0;
      end else begin
         valid <= 1'b0;
         brk   <= 1'b0;
         ferr  <= 1'b0;
         if (!en) begin
            st_q  <= RX_IDLE;
            cnt_q <= '0;
         end else begin
            case (st_q)
               RX_IDLE: begin
                  cnt_q <= '0;
                  if (!line) st_q <= RX_START;
               end
               RX_START: begin
                  if (cnt_q == half_m1) begin
                     cnt_q <= '0;
                     idx_q <= '0;
                     st_q  <= line ? RX_IDLE : RX_DATA;
                  end else begin
                     cnt_q <= cnt_q + CNT_W'(1);
                  end
               end
               RX_DATA: begin
                  if (cnt_q == full_m1) begin
                     cnt_q <= '0;
                     sh_q  <= {line, sh_q[7:1]};
                     idx_q <= idx_q + 3'd1;
                     if (idx_q == 3'd7) st_q <= RX_STOP;
                  end else begin
                     cnt_q <= cnt_q + CNT_W'(1);
                  end
               end
               RX_STOP: begin
                  if (cnt_q == full_m1) begin
                     cnt_q <= '0;
                     if (line) begin
                        valid <= 1'b1;
                        data  <= sh_q;
                        st_q  <= RX_IDLE;
                     end else begin
                        if (sh_q == 8'h00) brk  <= 1'b1;
                        else               ferr <= 1'b1;
                        st_q <= RX_WAIT_HI;
                     end
                  end else begin
                     cnt_q <= cnt_q + CNT_W'(1);
                  end
               end
               RX_WAIT_HI: begin
                  if (line) st_q <= RX_IDLE;
               end
               default: st_q <= RX_IDLE;
            endcase
         end
      end
   end

   // R10: event outputs last one clock
   assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);
   assert_break_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      brk |=> !brk);
   assert_ferr_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ferr |=> !ferr);

endmodule

// File: rtl/mon_sio_tx.sv
module mon_sio_tx
   import mon_sio_pkg::*;
#(
   parameter int unsigned CNT_W = 9,
   parameter int unsigned SEQ_W = ECHO_BITS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] bit_len,
   input  logic             load_byte,
   input  logic [7:0]       byte_in,
   input  logic             load_echo,
   output logic             active,
   output logic             pin
);

   localparam int unsigned LW = $clog2(SEQ_W + 1);

   generate
      if (SEQ_W < FRAME_BITS || SEQ_W < ECHO_BITS) begin : g_bad_seq
         $error("mon_sio_tx: SEQ_W too small for frame or echo");
      end
   endgenerate

   logic [SEQ_W-1:0] sh_q;
   logic [LW-1:0]    left_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] full_m1;

   assign full_m1 = bit_len - CNT_W'(1);
   assign active  = (left_q != '0);
   assign pin     = active ? sh_q[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '1;
         left_q <= '0;
         cnt_q  <= '0;
      end else if (load_echo) begin
         sh_q   <= SEQ_W'(ECHO_PAT);
         left_q <= LW'(ECHO_BITS);
         cnt_q  <= '0;
      end else if (load_byte) begin
         sh_q   <= SEQ_W'({1'b1, byte_in, 1'b0});
         left_q <= LW'(FRAME_BITS);
         cnt_q  <= '0;
      end else if (active) begin
         if (cnt_q == full_m1) begin
            cnt_q  <= '0;
            sh_q   <= {1'b1, sh_q[SEQ_W-1:1]};
            left_q <= left_q - LW'(1);
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

endmodule

// File: rtl/mon_sio.sv
module mon_sio
   import mon_sio_pkg::*;
#(
   parameter int unsigned DIV_EXT     = 256,
   parameter int unsigned DIV_INT     = 335,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       osc_int_sel,
   input  logic       pin_in,
   output logic       pin_out,
   output logic       pin_oe,
   input  logic       tx_req,
   input  logic [7:0] tx_data,
   output logic       tx_ready,
   output logic       tx_busy,
   output logic       rx_valid,
   output logic [7:0] rx_data,
   output logic       rx_break,
   output logic       rx_frame_err
);

   localparam int unsigned MAX_DIV = (DIV_EXT > DIV_INT) ? DIV_EXT : DIV_INT;
   localparam int unsigned CNT_W   = $clog2(MAX_DIV + 1);

   generate
      if (DIV_EXT < 8 || DIV_INT < 8) begin : g_bad_div
         $error("mon_sio: bit time must be at least 8 clocks");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("mon_sio: SYNC_STAGES above 4 eats into the sampling margin");
      end
   endgenerate

   logic [CNT_W-1:0] bit_len;
   logic             line_s;
   logic             rx_busy;
   logic             rx_line_hi;
   logic             tx_active;
   logic             tx_pin;
   logic             pend_q;
   logic [7:0]       pend_data_q;
   logic             start_echo;
   logic             start_byte;

   assign bit_len = osc_int_sel ? CNT_W'(DIV_INT) : CNT_W'(DIV_EXT);

   mon_sio_sync #(
      .STAGES (SYNC_STAGES),
      .INIT   (1'b1)
   ) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (line_s)
   );

   mon_sio_rx #(
      .CNT_W (CNT_W)
   ) rx_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (!tx_active),
      .line    (line_s),
      .bit_len (bit_len),
      .busy    (rx_busy),
      .line_hi (rx_line_hi),
      .valid   (rx_valid),
      .data    (rx_data),
      .brk     (rx_break),
      .ferr    (rx_frame_err)
   );

   assign start_echo = rx_break;
   assign start_byte = pend_q && !tx_active && !rx_busy && rx_line_hi && !start_echo;

   mon_sio_tx #(
      .CNT_W (CNT_W),
      .SEQ_W (ECHO_BITS)
   ) tx_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_len   (bit_len),
      .load_byte (start_byte),
      .byte_in   (pend_data_q),
      .load_echo (start_echo),
      .active    (tx_active),
      .pin       (tx_pin)
   );

   assign tx_ready = !pend_q && !tx_active;
   assign tx_busy  = tx_active;
   assign pin_oe   = tx_active;
   assign pin_out  = tx_pin;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q      <= 1'b0;
         pend_data_q <= '0;
      end else if (tx_req && tx_ready) begin
         pend_q      <= 1'b1;
         pend_data_q <= tx_data;
      end else if (start_byte) begin
         pend_q <= 1'b0;
      end
   end

   // R6: a break is answered by driving high in the very next cycle
   assert_break_echo_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_break |=> (pin_oe && pin_out));

   // R9: a held request does not seize the wire while a frame is arriving
   assert_hold_during_rx_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_busy && !rx_break && !pin_oe) |=> !pin_oe);

   // R11: own transmissions are never reported as received
   assert_no_rx_event_while_driving_R11: assert property (@(posedge clk) disable iff (!rst_n)
      pin_oe |-> !(rx_valid || rx_break || rx_frame_err));

   // R8: the wire is released only from a driven-high bit
   assert_release_from_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pin_oe) |-> $past(pin_out));

endmodule

// File: tb/mon_sio_tb_top.sv
`timescale 1ns/1ps
module mon_sio_tb_top;

   localparam int DIV_E = 16;
   localparam int DIV_I = 23;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       osc = 1'b0;
   logic       host_q = 1'b1;
   logic       tx_req = 1'b0;
   logic [7:0] tx_d = 8'h00;
   logic       pin_out, pin_oe, tx_ready, tx_busy;
   logic       rx_valid, rx_break, rx_frame_err;
   logic [7:0] rx_data;
   logic       line;

   // Pull-up wire: the port wins while it drives, otherwise the host level
   assign line = pin_oe ? pin_out : host_q;

   mon_sio #(
      .DIV_EXT     (DIV_E),
      .DIV_INT     (DIV_I),
      .SYNC_STAGES (2)
   ) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .osc_int_sel  (osc),
      .pin_in       (line),
      .pin_out      (pin_out),
      .pin_oe       (pin_oe),
      .tx_req       (tx_req),
      .tx_data      (tx_d),
      .tx_ready     (tx_ready),
      .tx_busy      (tx_busy),
      .rx_valid     (rx_valid),
      .rx_data      (rx_data),
      .rx_break     (rx_break),
      .rx_frame_err (rx_frame_err)
   );

   always #2.5 clk = ~clk;

   int         errs = 0;
   int         checks = 0;
   int         n_val = 0, n_brk = 0, n_fe = 0;
   int         run_v = 0, run_b = 0, run_f = 0, max_w = 0;
   int         busy_mismatch = 0;
   logic [7:0] last_d = 8'h00;
   longint     cyc = 0;

   always @(negedge clk) begin
      cyc++;
      if (rx_valid) begin n_val++; last_d = rx_data; end
      if (rx_break) n_brk++;
      if (rx_frame_err) n_fe++;
      run_v = rx_valid ? run_v + 1 : 0;
      run_b = rx_break ? run_b + 1 : 0;
      run_f = rx_frame_err ? run_f + 1 : 0;
      if (run_v > max_w) max_w = run_v;
      if (run_b > max_w) max_w = run_b;
      if (run_f > max_w) max_w = run_f;
      if (rst_n && (tx_busy !== pin_oe)) busy_mismatch++;
      if (cyc == 190000) begin
         errs++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected=<190000 cycles", cyc);
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int bl();
      return osc ? DIV_I : DIV_E;
   endfunction

   task automatic host_frame(input logic [9:0] bits);
      for (int i = 0; i < 10; i++) begin
         host_q = bits[i];
         repeat (bl()) @(negedge clk);
      end
      host_q = 1'b1;
   endtask

   task automatic idle_bits(input int n);
      repeat (n * bl()) @(negedge clk);
   endtask

   // Waits for the port to drive, then compares every cycle with the pattern
   task automatic capture(input logic [15:0] pat, input int nbits,
                          output int bad, output int len, output bit seen,
                          output longint t0);
      int t = 0;
      while (!pin_oe && t < 60 * bl()) begin
         @(negedge clk);
         t++;
      end
      seen = pin_oe;
      t0 = cyc;
      len = 0;
      bad = 0;
      while (pin_oe) begin
         if ((len / bl()) < nbits) begin
            if (pin_out !== pat[len / bl()]) bad++;
         end else begin
            bad++;
         end
         len++;
         @(negedge clk);
      end
   endtask

   task automatic send(input logic [7:0] d);
      while (!tx_ready) @(negedge clk);
      tx_d = d;
      tx_req = 1'b1;
      @(negedge clk);
      tx_req = 1'b0;
   endtask

   initial begin
      int bad, len, v0, b0, f0, leak;
      bit seen;
      longint t0, tf;
      logic [15:0] echo_pat;
      echo_pat = 16'b000_1_0000000000_11;

      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8 / R9: reset state
      chk(pin_oe == 1'b0, "R8", "oe after reset", pin_oe, 0);
      chk(tx_ready == 1'b1, "R9", "ready after reset", tx_ready, 1);
      chk(tx_busy == 1'b0, "R9", "busy after reset", tx_busy, 0);
      chk(n_val + n_brk + n_fe == 0, "R10", "events after reset", n_val + n_brk + n_fe, 0);

      // R1: every byte received at the external-oscillator bit time
      osc = 1'b0;
      idle_bits(1);
      for (int d = 0; d < 256; d++) begin
         v0 = n_val;
         host_frame({1'b1, 8'(d), 1'b0});
         idle_bits(1);
         chk(n_val == v0 + 1 && last_d == 8'(d), "R1", "rx byte", last_d, d);
      end

      // R3: receive at the internal-oscillator bit time
      osc = 1'b1;
      idle_bits(1);
      for (int k = 0; k < 4; k++) begin
         logic [7:0] dd;
         dd = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (k == 2) ? 8'h5A : 8'h81;
         v0 = n_val;
         host_frame({1'b1, dd, 1'b0});
         idle_bits(1);
         chk(n_val == v0 + 1 && last_d == dd, "R3", "rx byte slow mode", last_d, dd);
      end

      // R2 / R3 / R11: every byte sent at the internal-oscillator bit time
      leak = 0;
      for (int d = 0; d < 256; d++) begin
         v0 = n_val + n_brk + n_fe;
         send(8'(d));
         capture({6'b0, 1'b1, 8'(d), 1'b0}, 10, bad, len, seen, t0);
         chk(seen && bad == 0, "R2", "tx frame bits", bad, 0);
         chk(len == 10 * DIV_I, "R3", "tx frame length slow mode", len, 10 * DIV_I);
         if (n_val + n_brk + n_fe != v0) leak++;
      end
      chk(leak == 0, "R11", "rx events during own tx", leak, 0);

      // R3: transmit at the external-oscillator bit time
      osc = 1'b0;
      idle_bits(1);
      for (int k = 0; k < 3; k++) begin
         logic [7:0] dd;
         dd = (k == 0) ? 8'hC3 : (k == 1) ? 8'h01 : 8'h80;
         send(dd);
         capture({6'b0, 1'b1, dd, 1'b0}, 10, bad, len, seen, t0);
         chk(seen && bad == 0, "R2", "tx frame bits fast mode", bad, 0);
         chk(len == 10 * DIV_E, "R3", "tx frame length fast mode", len, 10 * DIV_E);
      end
      idle_bits(1);

      // R4: short low pulses are rejected at mid-bit
      for (int k = 0; k < 2; k++) begin
         v0 = n_val + n_brk + n_fe;
         host_q = 1'b0;
         repeat ((k == 0) ? DIV_E / 4 : DIV_E / 2 - 2) @(negedge clk);
         host_q = 1'b1;
         idle_bits(12);
         chk(n_val + n_brk + n_fe == v0, "R4", "glitch raised an event",
             n_val + n_brk + n_fe, v0);
      end

      // R7: low stop bit with nonzero data is a framing error
      for (int k = 0; k < 2; k++) begin
         logic [7:0] dd;
         dd = (k == 0) ? 8'h55 : 8'h80;
         v0 = n_val; b0 = n_brk; f0 = n_fe;
         host_frame({1'b0, dd, 1'b0});
         idle_bits(2);
         chk(n_fe == f0 + 1, "R7", "framing error count", n_fe, f0 + 1);
         chk(n_val == v0 && n_brk == b0, "R7", "no byte or break", n_val + n_brk, v0 + b0);
      end

      // R5 / R6: break detection and echo in both modes
      for (int m = 0; m < 2; m++) begin
         osc = m[0];
         idle_bits(1);
         v0 = n_val; b0 = n_brk;
         fork
            host_frame(10'b0);
            capture(echo_pat, 13, bad, len, seen, t0);
         join
         chk(n_brk == b0 + 1 && n_val == v0, "R5", "break event", n_brk, b0 + 1);
         chk(seen && bad == 0, "R6", "echo pattern", bad, 0);
         chk(len == 13 * bl(), "R6", "echo length", len, 13 * bl());
         idle_bits(1);
         host_frame({1'b1, 8'h3C, 1'b0});
         idle_bits(1);
         chk(n_val == v0 + 1 && last_d == 8'h3C, "R6", "rx after echo", last_d, 8'h3C);
      end

      // R9: a request made during a reception waits for the stop bit
      osc = 1'b0;
      idle_bits(1);
      tf = cyc;
      fork
         host_frame({1'b1, 8'hA5, 1'b0});
         begin
            idle_bits(3);
            send(8'h96);
            chk(tx_ready == 1'b0 && pin_oe == 1'b0, "R9", "request held",
                {tx_ready, pin_oe}, 0);
            capture({6'b0, 1'b1, 8'h96, 1'b0}, 10, bad, len, seen, t0);
         end
      join
      chk(seen && (t0 - tf) >= 9 * DIV_E && (t0 - tf) <= 11 * DIV_E, "R9",
          "held start time", t0 - tf, 9 * DIV_E);
      chk(bad == 0 && len == 10 * DIV_E, "R9", "held frame", bad, 0);
      chk(last_d == 8'hA5, "R1", "byte under held request", last_d, 8'hA5);
      chk(busy_mismatch == 0, "R9", "busy differs from drive", busy_mismatch, 0);

      // R10: all event pulses were one cycle wide
      chk(max_w == 1, "R10", "widest event pulse", max_w, 1);

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule